// File: doc/BRIEF.md
# Receive Byte Buffer with Interrupt Status Flags

This block sits between a packet radio's packet engine and a host processor. Demodulated payload bytes arrive on a push strobe and are held in a 66-entry byte queue. The host drains them through a pop port. The oldest stored byte is always visible on the read data output. A pop consumes that byte in the clock edge that follows.

The block keeps an 8-bit status word for the host's interrupt logic. The word reports:
- queue occupancy: full, not-empty, and above a programmable level;
- a sticky overrun condition;
- the payload-ready and CRC-good results of the packet now in the queue;
- a low-battery input, passed straight through.

The packet engine marks the end of each packet with a strobe that carries the CRC result. A host write that sets the overrun bit clears the overrun flag. The same write also flushes the whole queue, so the block can take a new reception at once.

Top module: `rx_fifo_status`

## Requirements
- R1: The queue stores up to 66 bytes. Status bit 7 (full) is 1 exactly when 66 bytes are stored.
- R2: Status bit 6 (not-empty) is 1 exactly when at least one byte is stored. After reset the queue is empty and the status word is zero, apart from bit 0.
- R3: Status bit 5 (level) is 1 only when the stored count is strictly greater than `thresh_i`. A count equal to `thresh_i` gives 0.
- R4: A push that arrives while the queue is full, with no accepted pop in the same cycle, is discarded. The stored bytes stay unchanged. Status bit 4 (overrun) is set on the next cycle, unless `sleep_i` is high. Once set, bit 4 stays set until it is cleared as in R5.
- R5: A register write with `reg_wdata_i[4]`=1 while bit 4 is set does three things on the next cycle: it clears bit 4, it empties the queue, and it clears bits 7, 6, 5, 2 and 1. A push or pop in that same cycle has no effect. When bit 4 is clear, such a write has no effect.
- R6: Status bit 2 (payload-ready) is set one cycle after `eop_i`, provided `rx_mode_i` is high and one of these holds:
  - `crc_en_i`=0;
  - `crc_keep_i`=1;
  - `crc_pass_i`=1.
  The bit stays set until the queue becomes empty, and it is 0 in the same cycle that bit 6 falls.
- R7: Status bit 1 (CRC-ok) is set one cycle after `eop_i`, provided `rx_mode_i` and `crc_pass_i` are both high. It clears together with bit 6, as in R6.
- R8: Status bit 3 always reads 0. Status bit 0 follows `lowbat_i` in the same cycle.
- R9: While the queue is empty, `pop_data_o` is 0. A pop while the queue is empty changes nothing.
- R10: A push and a pop in the same cycle on a full queue are both accepted. The queue stays full and the overrun flag does not change.
- R11: Bytes leave the queue in the order they were accepted. `pop_data_o` shows the oldest stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Push strobe from the packet engine |
| wr_data_i | input | 8 | Payload byte to push |
| eop_i | input | 1 | End-of-packet strobe |
| crc_pass_i | input | 1 | CRC result qualifying `eop_i` |
| crc_en_i | input | 1 | CRC checking enabled |
| crc_keep_i | input | 1 | Automatic discard on CRC error disabled |
| rx_mode_i | input | 1 | Receiver is in receive mode |
| sleep_i | input | 1 | Sleep mode; suppresses overrun |
| pop_i | input | 1 | Host pop strobe |
| pop_data_o | output | 8 | Oldest stored byte, 0 when empty |
| thresh_i | input | 7 | Level flag threshold |
| lowbat_i | input | 1 | Low-battery indication |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 8 | Status write data; bit 4 clears overrun |
| flags_o | output | 8 | Status word |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both.

- **Flush with a push and a pop.** Once the queue has overrun, the bench issues the overrun-clearing write together with a push and a pop. It expects an empty queue and a zero status word on the next cycle, with the incoming byte lost.
- **Push and pop on a full queue.** The bench pops and pushes together while the queue holds 66 bytes. It expects the queue to stay full, the overrun flag to stay as it was, and the new byte to appear last in pop order.

Random traffic is weighted toward pushes, so overrun followed by flush recurs many times. A reference queue in the bench judges every cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int FLG_FULL = 7;
  localparam int FLG_NE   = 6;
  localparam int FLG_LVL  = 5;
  localparam int FLG_OVR  = 4;
  localparam int FLG_RSV  = 3;
  localparam int FLG_PRDY = 2;
  localparam int FLG_CRC  = 1;
  localparam int FLG_LBAT = 0;

  typedef struct packed {
    logic full;
    logic ne;
    logic lvl;
    logic ovr;
    logic rsv;
    logic prdy;
    logic crc;
    logic lbat;
  } flags_t;
endpackage

// File: rtl/rxf_buffer.sv
module rxf_buffer #(
  parameter int DEPTH = 66,
  parameter int DW    = 8,
  parameter int CW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_nxt_o,
  output logic          drop_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, count_nxt;
  logic          full, empty, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);

  // flush overrides all traffic; a pop frees the slot a same-cycle push uses
  assign do_pop  = pop_i & ~empty & ~flush_i;
  assign do_push = push_i & ~flush_i & (~full | do_pop);
  assign drop_o  = push_i & ~flush_i & ~do_push;

  always_comb begin
    count_nxt = count_q;
    if (flush_i)                count_nxt = '0;
    else if (do_push && !do_pop) count_nxt = count_q + 1'b1;
    else if (do_pop && !do_push) count_nxt = count_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      count_q <= count_nxt;
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
        if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= push_data_i;
  end

  assign head_o      = empty ? '0 : mem[rd_ptr_q];
  assign count_o     = count_q;
  assign count_nxt_o = count_nxt;
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
#(
  parameter int DEPTH = 66,
  parameter int CW    = 7,
  parameter int TW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] count_nxt_i,
  input  logic          flush_i,
  input  logic          drop_i,
  input  logic          sleep_i,
  input  logic          eop_i,
  input  logic          rx_mode_i,
  input  logic          crc_en_i,
  input  logic          crc_keep_i,
  input  logic          crc_pass_i,
  input  logic [TW-1:0] thresh_i,
  input  logic          lowbat_i,
  output logic          ovr_o,
  output flags_t        flags_o
);
  localparam int MW = (CW > TW) ? CW : TW;

  logic ovr_q, prdy_q, crc_q;
  logic crc_gate, prdy_set, crc_set, drains;

  assign crc_gate = ~crc_en_i | crc_keep_i | crc_pass_i;
  assign prdy_set = rx_mode_i & eop_i & crc_gate;
  assign crc_set  = rx_mode_i & eop_i & crc_pass_i;
  // look ahead so packet flags fall in the same cycle as not-empty
  assign drains   = (count_nxt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= 1'b0;
      prdy_q <= 1'b0;
      crc_q  <= 1'b0;
    end else begin
      ovr_q  <= flush_i ? 1'b0 : (ovr_q | (drop_i & ~sleep_i));
      prdy_q <= drains ? 1'b0 : (prdy_q | prdy_set);
      crc_q  <= drains ? 1'b0 : (crc_q | crc_set);
    end
  end

  assign ovr_o = ovr_q;

  always_comb begin
    flags_o      = '0;
    flags_o.full = (count_i == CW'(DEPTH));
    flags_o.ne   = (count_i != '0);
    flags_o.lvl  = (MW'(count_i) > MW'(thresh_i));
    flags_o.ovr  = ovr_q;
    flags_o.rsv  = 1'b0;
    flags_o.prdy = prdy_q;
    flags_o.crc  = crc_q;
    flags_o.lbat = lowbat_i;
  end
endmodule

// File: rtl/rx_fifo_status.sv
module rx_fifo_status
  import rxf_pkg::*;
#(
  parameter int DEPTH = 66,
  parameter int DW    = 8,
  parameter int TW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          eop_i,
  input  logic          crc_pass_i,
  input  logic          crc_en_i,
  input  logic          crc_keep_i,
  input  logic          rx_mode_i,
  input  logic          sleep_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  input  logic [TW-1:0] thresh_i,
  input  logic          lowbat_i,
  input  logic          reg_wr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    flags_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count, count_nxt;
  logic          drop, ovr, flush;
  flags_t        flags;

  // write-one-to-clear acts only when overrun is actually pending
  assign flush = reg_wr_i & reg_wdata_i[FLG_OVR] & ovr;

  rxf_buffer #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_valid_i),
    .push_data_i (wr_data_i),
    .pop_i       (pop_i),
    .flush_i     (flush),
    .head_o      (pop_data_o),
    .count_o     (count),
    .count_nxt_o (count_nxt),
    .drop_o      (drop)
  );

  rxf_status #(.DEPTH(DEPTH), .CW(CW), .TW(TW)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_i     (count),
    .count_nxt_i (count_nxt),
    .flush_i     (flush),
    .drop_i      (drop),
    .sleep_i     (sleep_i),
    .eop_i       (eop_i),
    .rx_mode_i   (rx_mode_i),
    .crc_en_i    (crc_en_i),
    .crc_keep_i  (crc_keep_i),
    .crc_pass_i  (crc_pass_i),
    .thresh_i    (thresh_i),
    .lowbat_i    (lowbat_i),
    .ovr_o       (ovr),
    .flags_o     (flags)
  );

  assign flags_o = flags;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic          pop_i,
  input logic          sleep_i,
  input logic          reg_wr_i,
  input logic [7:0]    reg_wdata_i,
  input logic [DW-1:0] pop_data_o,
  input logic [7:0]    flags_o
);
  logic flush_req;
  assign flush_req = reg_wr_i & reg_wdata_i[4] & flags_o[4];

  p_full_has_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[7] |-> flags_o[6]);

  p_level_has_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[5] |-> flags_o[6]);

  p_overrun_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[7] && wr_valid_i && !pop_i && !sleep_i && !flush_req |=> flags_o[4]);

  p_drop_keeps_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[7] && wr_valid_i && !pop_i && !flush_req |=> flags_o[7]);

  p_flush_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req |=> (flags_o[7:4] == 4'h0) && (flags_o[2:1] == 2'b00));

  p_ready_has_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[2] |-> flags_o[6]);

  p_crc_has_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] |-> flags_o[6]);

  p_rsv_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[3] == 1'b0);

  p_empty_reads_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_o[6] |-> pop_data_o == '0);

  p_full_swap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[7] && wr_valid_i && pop_i && !flush_req |=> flags_o[7] && (flags_o[4] == $past(flags_o[4])));
endmodule

bind rx_fifo_status rxf_checker #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .pop_i       (pop_i),
  .sleep_i     (sleep_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .pop_data_o  (pop_data_o),
  .flags_o     (flags_o)
);

// File: tb/tb_rx_fifo_status.sv
module tb_rx_fifo_status;
  localparam int DEPTH = 66;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid_i = 0, eop_i = 0, crc_pass_i = 0, crc_en_i = 0, crc_keep_i = 0;
  logic       rx_mode_i = 0, sleep_i = 0, pop_i = 0, lowbat_i = 0, reg_wr_i = 0;
  logic [7:0] wr_data_i = 0, reg_wdata_i = 0, pop_data_o, flags_o;
  logic [6:0] thresh_i = 0;

  int checks = 0, errors = 0;
  logic [7:0] mq[$];
  bit m_ovr = 0, m_prdy = 0, m_crc = 0;

  always #10 clk_i = ~clk_i;

  rx_fifo_status dut (.*);

  function automatic logic [7:0] exp_flags();
    return {mq.size() == DEPTH, mq.size() != 0, mq.size() > int'(thresh_i),
            m_ovr, 1'b0, m_prdy, m_crc, lowbat_i};
  endfunction

  function automatic string bit_tag(input int b);
    case (b)
      7: return "R1";
      6: return "R2";
      5: return "R3";
      4: return "R4";
      2: return "R6";
      1: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_flags();
    logic [7:0] e;
    e = exp_flags();
    checks++;
    if (flags_o !== e) begin
      errors++;
      for (int b = 7; b >= 0; b--)
        if (flags_o[b] !== e[b]) begin
          $display("FAIL %s: flags actual %h expected %h at %0t", bit_tag(b), flags_o, e, $time);
          break;
        end
    end
  endtask

  // model of one clock edge, computed from the requirements
  function automatic void model_step();
    bit flush, full, dpop, dpush, drop;
    flush = reg_wr_i && reg_wdata_i[4] && m_ovr;
    if (flush) begin
      mq.delete();
      m_ovr = 0; m_prdy = 0; m_crc = 0;
      return;
    end
    full  = (mq.size() == DEPTH);
    dpop  = pop_i && mq.size() != 0;
    dpush = wr_valid_i && (!full || dpop);
    drop  = wr_valid_i && !dpush;
    if (dpop) void'(mq.pop_front());
    if (dpush) mq.push_back(wr_data_i);
    if (drop && !sleep_i) m_ovr = 1;
    if (rx_mode_i && eop_i && (!crc_en_i || crc_keep_i || crc_pass_i)) m_prdy = 1;
    if (rx_mode_i && eop_i && crc_pass_i) m_crc = 1;
    if (mq.size() == 0) begin m_prdy = 0; m_crc = 0; end
  endfunction

  task automatic tick();
    chk(pop_data_o, (mq.size() == 0) ? 8'h00 : mq[0], (mq.size() == 0) ? "R9" : "R11");
    model_step();
    @(negedge clk_i);
    chk_flags();
  endtask

  task automatic idle();
    wr_valid_i = 0; pop_i = 0; eop_i = 0; reg_wr_i = 0; reg_wdata_i = 0;
  endtask

  task automatic push(input logic [7:0] d);
    idle(); wr_valid_i = 1; wr_data_i = d; tick(); idle();
  endtask

  task automatic pop1();
    idle(); pop_i = 1; tick(); idle();
  endtask

  task automatic eop(input bit en, input bit keep, input bit pass);
    idle(); eop_i = 1; crc_en_i = en; crc_keep_i = keep; crc_pass_i = pass; tick(); idle();
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3b));
    repeat (3) @(negedge clk_i);
    chk(flags_o, 8'h00, "R2 reset");
    chk(pop_data_o, 8'h00, "R9 reset");
    rst_ni = 1;
    @(negedge clk_i);
    rx_mode_i = 1;

    // R3: equality vs strictly greater
    thresh_i = 7'd5;
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    chk({7'b0, flags_o[5]}, 8'h00, "R3 equal count");
    push(8'h15);
    chk({7'b0, flags_o[5]}, 8'h01, "R3 above");
    // R11 order, checked in tick while draining
    for (int i = 0; i < 6; i++) pop1();
    chk({7'b0, flags_o[6]}, 8'h00, "R2 drained");
    // R9 empty pop
    pop1();
    chk(pop_data_o, 8'h00, "R9 empty pop");
    chk(flags_o, 8'h00, "R9 empty pop flags");

    // R6/R7 packet flags
    push(8'hA1);
    eop(1, 0, 0);
    chk({6'b0, flags_o[2:1]}, 8'h00, "R6 crc fail");
    eop(1, 0, 1);
    chk({6'b0, flags_o[2:1]}, 8'h03, "R7 crc pass");
    pop1();
    chk({6'b0, flags_o[2:1]}, 8'h00, "R6 cleared on empty");
    push(8'hA2);
    eop(1, 1, 0);
    chk({6'b0, flags_o[2:1]}, 8'h02, "R6 keep set");
    eop(0, 0, 0);
    chk({6'b0, flags_o[2:1]}, 8'h02, "R7 no crc pass");
    pop1();

    // R8
    lowbat_i = 1; idle(); tick();
    chk({flags_o[3], flags_o[0]}, 8'h01, "R8 rsv and lowbat");
    lowbat_i = 0;

    // R1 fill
    thresh_i = 7'd65;
    for (int i = 0; i < DEPTH; i++) push(8'(i * 3 + 1));
    chk({7'b0, flags_o[7]}, 8'h01, "R1 full at 66");
    chk({7'b0, flags_o[5]}, 8'h01, "R3 66 above 65");
    // R4 sleep suppresses overrun
    sleep_i = 1; push(8'hEE); sleep_i = 0;
    chk({7'b0, flags_o[4]}, 8'h00, "R4 sleep no overrun");
    push(8'hEF);
    chk({7'b0, flags_o[4]}, 8'h01, "R4 overrun");
    chk(pop_data_o, 8'h01, "R4 head unchanged");
    // R10 swap on full
    idle(); wr_valid_i = 1; wr_data_i = 8'h77; pop_i = 1; tick(); idle();
    chk({7'b0, flags_o[7]}, 8'h01, "R10 stays full");
    chk(pop_data_o, 8'h04, "R10 next head");
    // R5 flush with colliding push and pop
    idle(); reg_wr_i = 1; reg_wdata_i = 8'h10; wr_valid_i = 1; wr_data_i = 8'h55; pop_i = 1; tick(); idle();
    chk(flags_o, 8'h00, "R5 flush");
    push(8'h31);
    idle(); reg_wr_i = 1; reg_wdata_i = 8'hFF; tick(); idle();
    chk({7'b0, flags_o[6]}, 8'h01, "R5 no overrun no flush");
    chk(pop_data_o, 8'h31, "R5 data kept");

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      wr_valid_i  = ($urandom_range(99) < 60);
      wr_data_i   = 8'($urandom);
      pop_i       = ($urandom_range(99) < 38);
      eop_i       = ($urandom_range(99) < 5);
      crc_en_i    = 1'($urandom);
      crc_keep_i  = 1'($urandom);
      crc_pass_i  = 1'($urandom);
      rx_mode_i   = ($urandom_range(99) < 85);
      sleep_i     = ($urandom_range(99) < 10);
      reg_wr_i    = ($urandom_range(99) < 3);
      reg_wdata_i = 8'($urandom);
      lowbat_i    = ($urandom_range(99) < 5);
      if ($urandom_range(99) < 2) thresh_i = 7'($urandom_range(70));
      tick();
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule